// File: doc/BRIEF.md
# Instruction Cycle Cost Calculator

This unit prices one retired instruction in core clock cycles. For each strobe it takes a decoded class, two attribute flags and a 16-bit register-list mask, and returns how many sequential (S), non-sequential (N) and internal (I) cycles the instruction occupies, along with their total. The result is registered and is valid in the cycle after the strobe.

The block also keeps a signed cycle budget. Every valid cost result is subtracted from it. A done flag reports when the budget has reached zero or gone below it. The budget can be reloaded synchronously, and a reload takes priority over the subtraction in the same cycle. A scheduler loads a time slice, streams retired instructions into the block, and stops issuing work once done is raised.

Top module: `cyc_cost_calc`

## Requirements
- R1: Class code 0 (data processing) without a program-counter destination costs 1S+0N+0I. `reg_shift_i`=1 adds 1I.
- R2: Class code 0 with `pc_dst_i`=1 costs 2S+1N. With `reg_shift_i`=1 as well, it costs 2S+1N+1I.
- R3: Class code 1 (halfword or signed load) costs 1S+1N+1I. With `pc_dst_i`=1 it costs 2S+2N+1I, which is a total of 5. `reg_shift_i` has no effect on this class.
- R4: Class code 2 (block load) with bit 15 of `reg_list_i` clear costs nS+1N+1I. Here n is the number of set bits in `reg_list_i`.
- R5: Class code 2 with bit 15 of `reg_list_i` set costs (n+1)S+2N+1I. For block classes, `pc_dst_i` and `reg_shift_i` have no effect.
- R6: Class code 3 (block store) costs (n-1)S+2N+0I. Here n counts every set bit of `reg_list_i`, including bit 15.
- R7: For classes 2 and 3, an all-zero `reg_list_i` is priced as n = 1.
- R8: When `req_vld_i` is high at a clock edge, `cost_vld_o` is high for the following cycle. In that cycle `s_cnt_o`, `n_cnt_o` and `i_cnt_o` show the price and `total_o` equals their sum. While no request arrives, the count outputs keep their last values.
- R9: When `bud_load_i` is high at an edge, `budget_o` takes the value of `bud_value_i`. This happens even if a debit is due in the same cycle.
- R10: At an edge where `cost_vld_o` is high and `bud_load_i` is low, `budget_o` decreases by `total_o`. At any other edge it holds its value.
- R11: `bud_done_o` is high exactly when `budget_o`, taken as signed, is less than or equal to zero.
- R12: During reset, all counts are zero, `cost_vld_o` is low, `budget_o` is zero and `bud_done_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_vld_i | input | 1 | Strobe: one retired instruction to price |
| req_cls_i | input | 2 | Class code: 0 data processing, 1 halfword/signed load, 2 block load, 3 block store |
| reg_shift_i | input | 1 | Shift amount taken from a register |
| pc_dst_i | input | 1 | Program counter is the destination (classes 0 and 1) |
| reg_list_i | input | 16 | Register-list mask for block classes; bit 15 is the program counter |
| bud_load_i | input | 1 | Synchronous budget reload |
| bud_value_i | input | 32 | Reload value, signed |
| cost_vld_o | output | 1 | Cost outputs refreshed this cycle |
| s_cnt_o | output | 5 | Sequential cycles |
| n_cnt_o | output | 5 | Non-sequential cycles |
| i_cnt_o | output | 5 | Internal cycles |
| total_o | output | 6 | S+N+I |
| budget_o | output | 32 | Remaining budget, signed |
| bud_done_o | output | 1 | Budget at or below zero |

## Verification
The bench targets the list extremes. A full 16-entry block load with the program counter would report 17S, so a design with an S field too narrow would wrap that value. An empty list exposes a design that underflows (n-1) on a store to a huge S count, and one that prices an empty load at zero S. It also covers a reload in the same cycle as a debit: a design with the wrong priority would leave the budget short by the total. Budgets that land exactly on zero and just above it catch a done comparison that is off by one. Flags that should be ignored are toggled on the classes that must ignore them, so an extra S or I cycle shows up at once.

// File: rtl/cyc_cost_pkg.sv
package cyc_cost_pkg;
  typedef enum logic [1:0] {
    CLS_ALU    = 2'd0,
    CLS_HLOAD  = 2'd1,
    CLS_BLOAD  = 2'd2,
    CLS_BSTORE = 2'd3
  } instr_cls_e;
endpackage

// File: rtl/cyc_popcnt.sv
module cyc_popcnt #(
  parameter int W     = 16,
  parameter int OUT_W = $clog2(W + 1)
) (
  input  logic [W-1:0]     vec_i,
  output logic [OUT_W-1:0] cnt_o
);
  always_comb begin
    cnt_o = '0;
    for (int b = 0; b < W; b++) begin
      cnt_o = cnt_o + OUT_W'(vec_i[b]);
    end
  end
endmodule

// File: rtl/cyc_cost_rules.sv
module cyc_cost_rules
  import cyc_cost_pkg::*;
#(
  parameter int N_W   = 5,
  parameter int CNT_W = 5
) (
  input  instr_cls_e       cls_i,
  input  logic             shift_i,
  input  logic             pc_dst_i,
  input  logic             pc_in_list_i,
  input  logic [N_W-1:0]   n_raw_i,
  output logic [CNT_W-1:0] s_o,
  output logic [CNT_W-1:0] n_o,
  output logic [CNT_W-1:0] i_o
);
  logic [CNT_W-1:0] n_eff;

  always_comb begin
    n_eff = (n_raw_i == '0) ? CNT_W'(1) : CNT_W'(n_raw_i);
    s_o   = '0;
    n_o   = '0;
    i_o   = '0;
    unique case (cls_i)
      CLS_ALU: begin
        s_o = pc_dst_i ? CNT_W'(2) : CNT_W'(1);
        n_o = pc_dst_i ? CNT_W'(1) : CNT_W'(0);
        i_o = CNT_W'(shift_i);
      end
      CLS_HLOAD: begin
        s_o = pc_dst_i ? CNT_W'(2) : CNT_W'(1);
        n_o = pc_dst_i ? CNT_W'(2) : CNT_W'(1);
        i_o = CNT_W'(1);
      end
      CLS_BLOAD: begin
        s_o = pc_in_list_i ? n_eff + CNT_W'(1) : n_eff;
        n_o = pc_in_list_i ? CNT_W'(2) : CNT_W'(1);
        i_o = CNT_W'(1);
      end
      CLS_BSTORE: begin
        s_o = n_eff - CNT_W'(1);
        n_o = CNT_W'(2);
        i_o = CNT_W'(0);
      end
      default: begin
        s_o = '0;
        n_o = '0;
        i_o = '0;
      end
    endcase
  end
endmodule

// File: rtl/cyc_budget.sv
module cyc_budget #(
  parameter int BUD_W = 32,
  parameter int SUM_W = 6
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    load_i,
  input  logic [BUD_W-1:0]        load_val_i,
  input  logic                    debit_en_i,
  input  logic [SUM_W-1:0]        debit_amt_i,
  output logic signed [BUD_W-1:0] budget_o,
  output logic                    done_o
);
  logic signed [BUD_W-1:0] bud_q, bud_d;
  logic                    bud_en;

  always_comb begin
    bud_en = load_i | debit_en_i;
    if (load_i) bud_d = $signed(load_val_i);
    else        bud_d = bud_q - $signed(BUD_W'(debit_amt_i));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      bud_q <= '0;
    else if (bud_en) bud_q <= bud_d;
  end

  assign budget_o = bud_q;
  assign done_o   = bud_q[BUD_W-1] | (bud_q == '0);
endmodule

// File: rtl/cyc_cost_calc.sv
module cyc_cost_calc
  import cyc_cost_pkg::*;
#(
  parameter int LIST_W = 16,
  parameter int CNT_W  = 5,
  parameter int SUM_W  = 6,
  parameter int BUD_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_vld_i,
  input  logic [1:0]        req_cls_i,
  input  logic              reg_shift_i,
  input  logic              pc_dst_i,
  input  logic [LIST_W-1:0] reg_list_i,
  input  logic              bud_load_i,
  input  logic [BUD_W-1:0]  bud_value_i,
  output logic              cost_vld_o,
  output logic [CNT_W-1:0]  s_cnt_o,
  output logic [CNT_W-1:0]  n_cnt_o,
  output logic [CNT_W-1:0]  i_cnt_o,
  output logic [SUM_W-1:0]  total_o,
  output logic [BUD_W-1:0]  budget_o,
  output logic              bud_done_o
);
  localparam int N_W = $clog2(LIST_W + 1);

  logic [N_W-1:0]   n_raw;
  logic [CNT_W-1:0] s_d, n_d, i_d;
  logic [SUM_W-1:0] tot_d;
  logic [CNT_W-1:0] s_q, n_q, i_q;
  logic [SUM_W-1:0] tot_q;
  logic             vld_q;
  logic signed [BUD_W-1:0] bud_s;

  cyc_popcnt #(.W(LIST_W), .OUT_W(N_W)) u_pop (
    .vec_i (reg_list_i),
    .cnt_o (n_raw)
  );

  cyc_cost_rules #(.N_W(N_W), .CNT_W(CNT_W)) u_rules (
    .cls_i        (instr_cls_e'(req_cls_i)),
    .shift_i      (reg_shift_i),
    .pc_dst_i     (pc_dst_i),
    .pc_in_list_i (reg_list_i[LIST_W-1]),
    .n_raw_i      (n_raw),
    .s_o          (s_d),
    .n_o          (n_d),
    .i_o          (i_d)
  );

  always_comb begin
    tot_d = SUM_W'(s_d) + SUM_W'(n_d) + SUM_W'(i_d);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
    end else begin
      vld_q <= req_vld_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_q   <= '0;
      n_q   <= '0;
      i_q   <= '0;
      tot_q <= '0;
    end else if (req_vld_i) begin
      s_q   <= s_d;
      n_q   <= n_d;
      i_q   <= i_d;
      tot_q <= tot_d;
    end
  end

  cyc_budget #(.BUD_W(BUD_W), .SUM_W(SUM_W)) u_bud (
    .clk         (clk),
    .rst_n       (rst_n),
    .load_i      (bud_load_i),
    .load_val_i  (bud_value_i),
    .debit_en_i  (vld_q),
    .debit_amt_i (tot_q),
    .budget_o    (bud_s),
    .done_o      (bud_done_o)
  );

  assign cost_vld_o = vld_q;
  assign s_cnt_o    = s_q;
  assign n_cnt_o    = n_q;
  assign i_cnt_o    = i_q;
  assign total_o    = tot_q;
  assign budget_o   = bud_s;
endmodule

// File: rtl/cyc_cost_calc_chk.sv
module cyc_cost_calc_chk #(
  parameter int LIST_W = 16,
  parameter int CNT_W  = 5,
  parameter int SUM_W  = 6,
  parameter int BUD_W  = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_vld_i,
  input logic [1:0]        req_cls_i,
  input logic              reg_shift_i,
  input logic              pc_dst_i,
  input logic [LIST_W-1:0] reg_list_i,
  input logic              bud_load_i,
  input logic [BUD_W-1:0]  bud_value_i,
  input logic              cost_vld_o,
  input logic [CNT_W-1:0]  s_cnt_o,
  input logic [CNT_W-1:0]  n_cnt_o,
  input logic [CNT_W-1:0]  i_cnt_o,
  input logic [SUM_W-1:0]  total_o,
  input logic [BUD_W-1:0]  budget_o,
  input logic              bud_done_o
);
  assert_vld_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
    req_vld_i |=> cost_vld_o);

  assert_vld_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !req_vld_i |=> (!cost_vld_o && $stable(total_o)));

  assert_alu_plain_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld_i && req_cls_i == 2'd0 && !pc_dst_i && !reg_shift_i)
    |=> (s_cnt_o == CNT_W'(1) && n_cnt_o == '0 && i_cnt_o == '0));

  assert_store_cost_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld_i && req_cls_i == 2'd3 && reg_list_i != '0)
    |=> (s_cnt_o == CNT_W'($past($countones(reg_list_i)) - 1) && n_cnt_o == CNT_W'(2) && i_cnt_o == '0));

  assert_load_prio_R9: assert property (@(posedge clk) disable iff (!rst_n)
    bud_load_i |=> (budget_o == $past(bud_value_i)));

  assert_debit_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cost_vld_o && !bud_load_i) |=> (budget_o == $past(budget_o) - BUD_W'($past(total_o))));

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!cost_vld_o && !bud_load_i) |=> $stable(budget_o));
endmodule

bind cyc_cost_calc cyc_cost_calc_chk #(
  .LIST_W(LIST_W), .CNT_W(CNT_W), .SUM_W(SUM_W), .BUD_W(BUD_W)
) chk_i (.*);

// File: tb/cyc_cost_calc_tb.sv
module cyc_cost_calc_tb_top;
  logic        clk;
  logic        rst_n;
  logic        req_vld_i;
  logic [1:0]  req_cls_i;
  logic        reg_shift_i;
  logic        pc_dst_i;
  logic [15:0] reg_list_i;
  logic        bud_load_i;
  logic [31:0] bud_value_i;
  logic        cost_vld_o;
  logic [4:0]  s_cnt_o, n_cnt_o, i_cnt_o;
  logic [5:0]  total_o;
  logic [31:0] budget_o;
  logic        bud_done_o;

  int n_vec, n_bad;
  bit finished;

  int m_s, m_n, m_i, m_tot, m_bud;
  bit m_vld;

  cyc_cost_calc dut_i (.*);

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(string tag, int act, int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int list_n(logic [15:0] l);
    int c = $countones(l);
    return (c == 0) ? 1 : c;
  endfunction

  function automatic void price(input int cls, input bit sh, input bit pc,
                                input logic [15:0] l, output int s, output int n, output int i);
    int k = list_n(l);
    case (cls)
      0: begin s = pc ? 2 : 1; n = pc ? 1 : 0; i = sh ? 1 : 0; end
      1: begin s = pc ? 2 : 1; n = pc ? 2 : 1; i = 1; end
      2: begin s = l[15] ? k + 1 : k; n = l[15] ? 2 : 1; i = 1; end
      default: begin s = k - 1; n = 2; i = 0; end
    endcase
  endfunction

  function automatic string tag_of(int cls, bit pc, logic [15:0] l);
    if (cls >= 2 && l == 16'h0) return "R7";
    case (cls)
      0: return pc ? "R2" : "R1";
      1: return "R3";
      2: return l[15] ? "R5" : "R4";
      default: return "R6";
    endcase
  endfunction

  task automatic step(bit rq, int cls, bit sh, bit pc, logic [15:0] l, bit ld, int ldv);
    string t;
    bit ld_now;
    req_vld_i   = rq;
    req_cls_i   = 2'(cls);
    reg_shift_i = sh;
    pc_dst_i    = pc;
    reg_list_i  = l;
    bud_load_i  = ld;
    bud_value_i = ldv;
    t = tag_of(cls, pc, l);
    ld_now = ld;
    @(posedge clk);
    if (ld) m_bud = ldv;
    else if (m_vld) m_bud = m_bud - m_tot;
    if (rq) begin
      price(cls, sh, pc, l, m_s, m_n, m_i);
      m_tot = m_s + m_n + m_i;
    end
    m_vld = rq;
    @(negedge clk);
    chk("R8 vld", int'(cost_vld_o), int'(m_vld));
    chk(rq ? t : "R8 hold", int'(s_cnt_o), m_s);
    chk(rq ? t : "R8 hold", int'(n_cnt_o), m_n);
    chk(rq ? t : "R8 hold", int'(i_cnt_o), m_i);
    chk("R8 total", int'(total_o), m_tot);
    chk(ld_now ? "R9" : "R10", $signed(budget_o), m_bud);
    chk("R11", int'(bud_done_o), (m_bud <= 0) ? 1 : 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    n_vec = 0; n_bad = 0; finished = 0;
    m_s = 0; m_n = 0; m_i = 0; m_tot = 0; m_bud = 0; m_vld = 0;
    rst_n = 1'b0;
    req_vld_i = 0; req_cls_i = 0; reg_shift_i = 0; pc_dst_i = 0;
    reg_list_i = 0; bud_load_i = 0; bud_value_i = 0;
    repeat (3) @(negedge clk);
    chk("R12 vld", int'(cost_vld_o), 0);
    chk("R12 s", int'(s_cnt_o), 0);
    chk("R12 total", int'(total_o), 0);
    chk("R12 budget", $signed(budget_o), 0);
    chk("R12 done", int'(bud_done_o), 1);
    rst_n = 1'b1;
    @(negedge clk);

    // directed corners
    step(0, 0, 0, 0, 16'h0, 1, 1000);
    step(1, 0, 0, 0, 16'h0, 0, 0);          // R1 plain
    step(1, 0, 1, 0, 16'h0, 0, 0);          // R1 shift
    step(1, 0, 0, 1, 16'h0, 0, 0);          // R2
    step(1, 0, 1, 1, 16'h0, 0, 0);          // R2 with shift
    step(1, 1, 1, 0, 16'h0, 0, 0);          // R3 shift ignored
    step(1, 1, 0, 1, 16'h0, 0, 0);          // R3 pc dest, total 5
    step(1, 2, 1, 1, 16'h00F0, 0, 0);       // R4, flags ignored
    step(1, 2, 0, 0, 16'hFFFF, 0, 0);       // R5 full list, 17S
    step(1, 2, 0, 0, 16'h8000, 0, 0);       // R5 only pc
    step(1, 2, 0, 0, 16'h0000, 0, 0);       // R7 load empty
    step(1, 3, 0, 0, 16'h0000, 0, 0);       // R7 store empty
    step(1, 3, 1, 1, 16'hFFFF, 0, 0);       // R6 full
    step(1, 3, 0, 0, 16'h8001, 0, 0);       // R6 includes bit 15
    step(1, 0, 0, 0, 16'h0, 1, 7);          // R9 load wins over debit
    step(1, 3, 0, 0, 16'hFFFF, 1, 4);       // R9 again
    step(1, 1, 0, 0, 16'h0, 0, 0);          // debit 17 -> -13
    step(0, 0, 0, 0, 16'h0, 1, 3);
    step(1, 1, 0, 0, 16'h0, 0, 0);
    step(0, 0, 0, 0, 16'h0, 0, 0);          // exactly zero, R11
    step(0, 0, 0, 0, 16'h0, 1, 2);
    step(1, 0, 0, 0, 16'h0, 0, 0);
    step(0, 0, 0, 0, 16'h0, 0, 0);          // 1 left, not done
    step(0, 0, 0, 0, 16'h0, 0, 0);          // hold

    // constrained random
    void'($urandom(32'd20240611));
    for (int k = 0; k < 3000; k++) begin
      int sel, cls, ldv;
      bit rq, sh, pc, ld;
      logic [15:0] l;
      rq  = ($urandom_range(0, 3) != 0);
      cls = $urandom_range(0, 3);
      sh  = 1'($urandom_range(0, 1));
      pc  = 1'($urandom_range(0, 1));
      sel = $urandom_range(0, 9);
      if (sel == 0)      l = 16'h0000;
      else if (sel == 1) l = 16'hFFFF;
      else               l = 16'($urandom());
      ld  = ($urandom_range(0, 29) == 0);
      ldv = $urandom_range(0, 300);
      step(rq, cls, sh, pc, l, ld, ldv);
    end

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule